// File: doc/BRIEF.md
# Parity-Guarded Register Group

This block stores several groups of functional flip-flops. Each group has its own load enable and one extra shadow flip-flop that holds the even parity of the group's contents. When a group loads new data, the shadow flop takes the parity of that data on the same clock edge, with the same reset and the same enable. On every cycle the block computes parity again over the stored bits and compares the result with the shadow flop. A disagreement means an upset hit either a data flop or the shadow flop. That disagreement is registered into a per-group fault line. All group fault lines of the unit are merged by OR into a single unit fault line.

A test-only flip vector per group can invert any stored bit at a clock edge, the shadow bit included. It models single and multiple transient upsets. Correction and recovery are not part of the block. A reload with fresh data brings a group back to a consistent state.

Top module: `pg_guard_unit`

## Requirements
- R1: After reset, every data output bit is 0, every group fault bit is 0 and the unit fault is 0.
- R2: When a group's load enable is high at a clock edge and its flip vector is zero, that group's data output equals the loaded input after the edge, and no fault is raised for any loaded pattern.
- R3: While a group's load enable is low and its flip vector is zero, its data output holds its value.
- R4: A single inverted data bit is detected. If flip bit i (0 ≤ i < W, field at bits g*(W+1)+i of the flip vector) is set at an edge, the data output shows that bit inverted after that edge, and the group fault is 1 after the following edge.
- R5: Inverting the shadow parity bit alone (flip bit W of the group's field) leaves the data output unchanged and sets the group fault one edge later.
- R6: An even number of inverted bits within one group is not detected. The group fault stays 0.
- R7: The unit fault is the OR of the group faults. A fault in one group sets only that group's bit in the group fault vector (bit g belongs to group g).
- R8: Loading fresh data into a faulty group clears its fault: the fault is still 1 after the load edge and 0 after the next edge.
- R9: The group fault is registered. It is still 0 in the cycle in which the corrupted state first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all groups |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | NGRP | Load enable, one bit per group |
| din | input | NGRP*W | Load data, group g at bits g*W +: W |
| flip | input | NGRP*(W+1) | Test upset vector; group g field at g*(W+1), bit W of a field is the shadow bit |
| dout | output | NGRP*W | Stored data, group g at bits g*W +: W |
| grp_fault | output | NGRP | Registered per-group mismatch |
| unit_fault | output | 1 | OR of all group faults |

## Verification
The bench targets the one-cycle lag of the fault line. A design that compared state combinationally would show the fault in the same cycle the upset appears. A design that used a stale parity would miss it. Upsets that hit only the shadow bit check that the comparison covers the shadow flop, and not just a recomputation over the data. Double upsets check the documented blind spot: a design that counted flips, rather than comparing parity, would wrongly flag them. Upsets injected into two groups at once check that the unit line merges by OR and that fault bits do not land on the wrong group. Reloads check that a design whose fault latched forever, or cleared too early, is caught.

// File: rtl/pg_pkg.sv
package pg_pkg;
    parameter int unsigned PG_WIDTH_DEF = 16;
    parameter int unsigned PG_GROUPS_DEF = 4;

    typedef enum logic [1:0] {
        PG_HOLD  = 2'd0,
        PG_LOAD  = 2'd1,
        PG_UPSET = 2'd2
    } pg_op_e;
endpackage

// File: rtl/pg_parity_calc.sv
module pg_parity_calc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    assign odd_o = ^bits_i;
endmodule

// File: rtl/pg_group.sv
module pg_group
    import pg_pkg::*;
#(
    parameter int unsigned W = PG_WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic [W:0]   flip_i,
    output logic [W-1:0] dout_o,
    output logic         fault_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         par;
        logic         fault;
    } grp_st_t;

    grp_st_t st_d, st_q;
    pg_op_e  op;
    logic    new_par;
    logic    held_par;
    logic    mismatch;

    pg_parity_calc #(.W(W)) wr_calc_i (.bits_i(din_i),      .odd_o(new_par));
    pg_parity_calc #(.W(W)) rd_calc_i (.bits_i(st_q.data),  .odd_o(held_par));

    always_comb begin
        mismatch = held_par ^ st_q.par;
        if (load_i)            op = PG_LOAD;
        else if (|flip_i)      op = PG_UPSET;
        else                   op = PG_HOLD;

        st_d       = st_q;
        st_d.fault = mismatch;
        unique case (op)
            PG_LOAD: begin
                st_d.data = din_i ^ flip_i[W-1:0];
                st_d.par  = new_par ^ flip_i[W];
            end
            PG_UPSET: begin
                st_d.data = st_q.data ^ flip_i[W-1:0];
                st_d.par  = st_q.par ^ flip_i[W];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o  = st_q.data;
    assign fault_o = st_q.fault;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && flip_i == '0) |=> $stable(dout_o));

    // R4
    odd_upset_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !mismatch && ($countones(flip_i) % 2 == 1)) |=> ##1 fault_o);

    // R8
    clean_load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && flip_i == '0) |=> ##1 !fault_o);

    // R6
    even_upset_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !mismatch && flip_i != '0 && ($countones(flip_i) % 2 == 0)) |=> ##1 !fault_o);
endmodule

// File: rtl/pg_fault_merge.sv
module pg_fault_merge #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] flags_i,
    output logic         any_o
);
    always_comb begin
        any_o = 1'b0;
        for (int i = 0; i < N; i++) any_o = any_o | flags_i[i];
    end
endmodule

// File: rtl/pg_guard_unit.sv
module pg_guard_unit
    import pg_pkg::*;
#(
    parameter int unsigned W    = PG_WIDTH_DEF,
    parameter int unsigned NGRP = PG_GROUPS_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NGRP-1:0]       load_en,
    input  logic [NGRP*W-1:0]     din,
    input  logic [NGRP*(W+1)-1:0] flip,
    output logic [NGRP*W-1:0]     dout,
    output logic [NGRP-1:0]       grp_fault,
    output logic                  unit_fault
);
    localparam int unsigned FW = W + 1;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pg_group #(.W(W)) grp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_en[g]),
            .din_i   (din[g*W +: W]),
            .flip_i  (flip[g*FW +: FW]),
            .dout_o  (dout[g*W +: W]),
            .fault_o (grp_fault[g])
        );

        // R2
        load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_en[g] && flip[g*FW +: FW] == '0) |=> (dout[g*W +: W] == $past(din[g*W +: W])));
    end

    pg_fault_merge #(.N(NGRP)) merge_i (
        .flags_i (grp_fault),
        .any_o   (unit_fault)
    );

    // R7
    unit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_fault == '0) |-> !unit_fault);
endmodule

// File: tb/pg_guard_unit_tb_top.sv
module pg_guard_unit_tb_top;
    localparam int W = 8;
    localparam int NG = 3;
    localparam int FW = W + 1;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG-1:0]     load_en = '0;
    logic [NG*W-1:0]   din = '0;
    logic [NG*FW-1:0]  flip = '0;
    logic [NG*W-1:0]   dout;
    logic [NG-1:0]     grp_fault;
    logic              unit_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_d [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_guard_unit #(.W(W), .NGRP(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .din(din), .flip(flip),
        .dout(dout), .grp_fault(grp_fault), .unit_fault(unit_fault)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_data(input string req);
        for (int g = 0; g < NG; g++)
            chk(req, $sformatf("dout g%0d", g), 32'(dout[g*W +: W]), 32'(exp_d[g]));
    endtask

    task automatic load_grp(input int g, input logic [W-1:0] v);
        load_en[g] = 1'b1;
        din[g*W +: W] = v;
        step();
        load_en[g] = 1'b0;
        exp_d[g] = v;
    endtask

    task automatic t_reset();
        for (int g = 0; g < NG; g++) exp_d[g] = '0;
        chk_data("R1");
        chk("R1", "grp_fault", 32'(grp_fault), 0);
        chk("R1", "unit_fault", 32'(unit_fault), 0);
    endtask

    task automatic t_load_hold();
        load_grp(0, 8'hA5);
        load_grp(1, 8'hFF);
        load_grp(2, 8'h01);
        chk_data("R2");
        step();
        chk("R2", "grp_fault after loads", 32'(grp_fault), 0);
        din = '1;
        repeat (3) step();
        chk_data("R3");
        chk("R3", "grp_fault while holding", 32'(grp_fault), 0);
    endtask

    task automatic t_single_data();
        flip[1*FW + 3] = 1'b1;
        step();
        flip = '0;
        exp_d[1] = exp_d[1] ^ 8'h08;
        chk_data("R4");
        chk("R9", "fault before register", 32'(grp_fault), 0);
        step();
        chk("R4", "grp_fault single data flip", 32'(grp_fault), 32'b010);
        chk("R7", "unit_fault single group", 32'(unit_fault), 1);
    endtask

    task automatic t_reload();
        load_grp(1, 8'h3C);
        chk("R8", "fault right after reload", 32'(grp_fault), 32'b010);
        step();
        chk("R8", "fault cleared", 32'(grp_fault), 0);
        chk("R8", "unit cleared", 32'(unit_fault), 0);
        chk_data("R8");
    endtask

    task automatic t_parity_flip();
        flip[2*FW + W] = 1'b1;
        step();
        flip = '0;
        chk_data("R5");
        chk("R9", "parity flip not yet seen", 32'(grp_fault), 0);
        step();
        chk("R5", "grp_fault parity flip", 32'(grp_fault), 32'b100);
        chk("R5", "unit_fault parity flip", 32'(unit_fault), 1);
        load_grp(2, 8'h5A);
        step();
        chk("R8", "parity fault cleared", 32'(grp_fault), 0);
    endtask

    task automatic t_double_flip();
        flip[0*FW + 0] = 1'b1;
        flip[0*FW + 7] = 1'b1;
        step();
        flip = '0;
        exp_d[0] = exp_d[0] ^ 8'h81;
        chk_data("R6");
        step();
        chk("R6", "double flip undetected", 32'(grp_fault), 0);
        step();
        chk("R6", "unit still quiet", 32'(unit_fault), 0);
        flip[1*FW + 2] = 1'b1;
        flip[1*FW + W] = 1'b1;
        step();
        flip = '0;
        exp_d[1] = exp_d[1] ^ 8'h04;
        step();
        chk("R6", "data plus parity flip undetected", 32'(grp_fault), 0);
        chk_data("R6");
    endtask

    task automatic t_two_groups();
        flip[0*FW + 5] = 1'b1;
        flip[2*FW + 1] = 1'b1;
        step();
        flip = '0;
        exp_d[0] = exp_d[0] ^ 8'h20;
        exp_d[2] = exp_d[2] ^ 8'h02;
        step();
        chk("R7", "grp_fault two groups", 32'(grp_fault), 32'b101);
        chk("R7", "unit_fault two groups", 32'(unit_fault), 1);
        chk_data("R4");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_load_hold();
        t_single_data();
        t_reload();
        t_parity_flip();
        t_double_flip();
        t_two_groups();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule